// File: doc/BRIEF.md
# Character-Level Serial Port Peripheral

This block is a register-mapped serial port that moves whole characters instead of serial bits. A host reaches it through a simple byte-wide register bus with separate read and write strobes. Receive and transmit each take place on a character port that offers at most one byte per slot. A 16-bit divisor sets a slow-down factor `b`, and both ports advance only once every `b` clocks. Each direction holds a single character. The host works the port by polling a status register: it checks the holding-empty bit before it writes a byte, and it checks the data-ready bit before it reads one.

Any access that is illegal or would corrupt data does not pass silently. The block suppresses its effect and raises an error output. That output stays high until reset, so the surrounding system can prove that the software driving the port never made such an access.

Top module: `chr_uart`

## Requirements
- R1: After reset, the divisor is 0, line control is 0x00 (divisor access bit clear), status reads 0x60 (holding-empty in bit 5 and transmitter-empty in bit 6 set; data-ready in bit 0 and overrun in bit 1 clear), and the error output is low.
- R2: The byte offsets are decoded as follows.
  - Offset 12 is line control (read/write). Its bit 7 is the divisor access bit.
  - While that bit is clear, a read of offset 0 returns the receive buffer and a write of offset 0 loads the transmit holding register.
  - While that bit is set, offsets 0 and 4 read and write the divisor low byte and high byte.
  - Offset 8 is FIFO control (write-only).
  - Offset 20 is status (read-only).
  - Offset 28 is scratch (read/write).
  - Read data is combinational in the cycle of the read. It is 0 when no legal read is made.
- R3: The slow-down factor is b = {high, low}, or 1 when the divisor is 0. A slot tick occurs once every b clocks. The receive port is sampled and the transmit port is updated only on a tick.
- R4: A write of offset 0 while holding-empty is set clears status bits 5 and 6. At the next tick, the byte appears on `txValid`/`txByte` for exactly one clock, the clock after the tick, and bits 5 and 6 are set again. A write made in the tick clock itself is emitted at that tick.
- R5: On a tick with `rxValid` high, the byte is stored and status bit 0 is set. Reading offset 0 returns the byte and clears bit 0.
- R6: If a byte arrives on a tick while data-ready is still set and not being read in that clock, status bit 1 (overrun) is set and the buffer is overwritten. Reading status clears bit 1.
- R7: Writing 0x01 to FIFO control empties both directions: bits 0 and 1 clear, bits 5 and 6 set, and any pending transmit byte is dropped.
- R8: The error output rises one clock after any of these accesses:
  - an unmapped offset, including offset 4 with the divisor access bit clear;
  - a read of FIFO control, or a write of status;
  - a FIFO control write other than 0x01 (bits 7:1 are reserved, bit 0 must be 1);
  - a read of the receive buffer with data-ready clear;
  - a write of the holding register with holding-empty clear.
  Once high, it stays high until reset.
- R9: An access flagged as an error changes no register, flag or stream, and its read data is 0.
- R10: Whenever transmitter-empty is set, holding-empty is set. Whenever the slot counter is 0, holding-empty is set.
- R11: Asserting read and write strobes in the same clock is an error under R8 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Register byte offset |
| busWdata | input | 8 | Write data |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busRdata | output | 8 | Read data, valid in the read clock |
| busErr | output | 1 | Sticky illegal-access flag |
| rxValid | input | 1 | A character is present in the current receive slot |
| rxByte | input | 8 | Receive character |
| txValid | output | 1 | A character leaves in this slot |
| txByte | output | 8 | Transmit character |

## Verification
Read data is due in the same clock as the read strobe. Every side effect of an access appears one clock later, and that includes the error flag. A transmitted byte shows on the port in the clock after the tick that sends it. Inputs are driven just after the rising edge and outputs are sampled at the falling edge. A behavioural reference in the bench advances at each rising edge under the same access-then-slot ordering, so every sample is compared against the value due in that clock. The directed checks measure slot spacing in clocks and poll for transmit pulses before they time-sensitive accesses, so that the cycle in which a check lands is known.

// File: rtl/chr_uart_pkg.sv
package chr_uart_pkg;
  localparam int CHAR_W = 8;

  localparam int OFF_DATA = 0;
  localparam int OFF_DIVHI = 4;
  localparam int OFF_FIFO = 8;
  localparam int OFF_LINE = 12;
  localparam int OFF_STAT = 20;
  localparam int OFF_SCR = 28;

  localparam int LINE_DLAB_BIT = 7;
  localparam logic [CHAR_W-1:0] FIFO_LEGAL = 8'h01;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_RBR, SEL_DLL, SEL_DLM, SEL_LINE, SEL_STAT, SEL_SCR
  } rdSel_e;

  typedef struct packed {
    logic tick;
    logic illegal;
    logic rbrRd;
    logic statRd;
    logic thrWr;
    logic fifoWr;
    logic lineWr;
    logic scrWr;
    logic dllWr;
    logic dlmWr;
  } strobe_t;
endpackage

// File: rtl/chr_uart_ctrl.sv
module chr_uart_ctrl
  import chr_uart_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [CHAR_W-1:0] busWdata,
  input  logic              dlab,
  input  logic              rxReady,
  input  logic              holdEmpty,
  input  logic [DIV_W-1:0]  divisor,
  output strobe_t           stb,
  output rdSel_e            rdSel,
  output logic [DIV_W-1:0]  slotCnt
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_DIVHI = ADDR_W'(OFF_DIVHI);
  localparam logic [ADDR_W-1:0] A_FIFO = ADDR_W'(OFF_FIFO);
  localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(OFF_LINE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_SCR = ADDR_W'(OFF_SCR);

  logic [DIV_W-1:0] lastCnt;
  logic tick;

  // b = divisor, or 1 for a zero divisor; counter runs 0..b-1
  assign lastCnt = (divisor == '0) ? '0 : divisor - DIV_W'(1);
  // >= so that shrinking the divisor never strands the counter
  assign tick = (slotCnt >= lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slotCnt <= '0;
    else if (tick) slotCnt <= '0;
    else slotCnt <= slotCnt + DIV_W'(1);
  end

  always_comb begin
    stb = '0;
    stb.tick = tick;
    rdSel = SEL_NONE;
    if (busRd && busWr) begin
      stb.illegal = 1'b1;
    end else if (busRd) begin
      case (busAddr)
        A_DATA: begin
          if (dlab) rdSel = SEL_DLL;
          else if (rxReady) begin
            rdSel = SEL_RBR;
            stb.rbrRd = 1'b1;
          end else stb.illegal = 1'b1;
        end
        A_DIVHI: begin
          if (dlab) rdSel = SEL_DLM;
          else stb.illegal = 1'b1;
        end
        A_LINE: rdSel = SEL_LINE;
        A_STAT: begin
          rdSel = SEL_STAT;
          stb.statRd = 1'b1;
        end
        A_SCR: rdSel = SEL_SCR;
        default: stb.illegal = 1'b1;
      endcase
    end else if (busWr) begin
      case (busAddr)
        A_DATA: begin
          if (dlab) stb.dllWr = 1'b1;
          else if (holdEmpty) stb.thrWr = 1'b1;
          else stb.illegal = 1'b1;
        end
        A_DIVHI: begin
          if (dlab) stb.dlmWr = 1'b1;
          else stb.illegal = 1'b1;
        end
        A_FIFO: begin
          if (busWdata == FIFO_LEGAL) stb.fifoWr = 1'b1;
          else stb.illegal = 1'b1;
        end
        A_LINE: stb.lineWr = 1'b1;
        A_SCR: stb.scrWr = 1'b1;
        default: stb.illegal = 1'b1;
      endcase
    end
  end

  // R3: a slot tick restarts the period
  p_tick_restarts_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.tick |=> (slotCnt == '0));
endmodule

// File: rtl/chr_uart_dp.sv
module chr_uart_dp
  import chr_uart_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  rdSel_e            rdSel,
  input  logic [CHAR_W-1:0] busWdata,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxByte,
  input  logic [DIV_W-1:0]  slotCnt,
  output logic              dlab,
  output logic              rxReady,
  output logic              holdEmpty,
  output logic [DIV_W-1:0]  divisor,
  output logic [CHAR_W-1:0] busRdata,
  output logic              busErr,
  output logic              txValid,
  output logic [CHAR_W-1:0] txByte
);
  logic [CHAR_W-1:0] rbr, thr, scr, dll, dlm, lineReg;
  logic ovr, txEmpty;
  logic [CHAR_W-1:0] rbrN, thrN, txbN;
  logic rdrN, ovrN, hempN, tempN, txvN;
  logic [CHAR_W-1:0] statVal;

  assign dlab = lineReg[LINE_DLAB_BIT];
  assign divisor = {dlm, dll};

  always_comb begin
    statVal = '0;
    statVal[0] = rxReady;
    statVal[1] = ovr;
    statVal[5] = holdEmpty;
    statVal[6] = txEmpty;
  end

  // bus access first, then the slot action of the same clock
  always_comb begin
    rdrN = rxReady;
    ovrN = ovr;
    hempN = holdEmpty;
    tempN = txEmpty;
    thrN = thr;
    rbrN = rbr;
    txvN = 1'b0;
    txbN = txByte;
    if (stb.rbrRd) rdrN = 1'b0;
    if (stb.statRd) ovrN = 1'b0;
    if (stb.thrWr) begin
      thrN = busWdata;
      hempN = 1'b0;
      tempN = 1'b0;
    end
    if (stb.fifoWr) begin
      rdrN = 1'b0;
      ovrN = 1'b0;
      hempN = 1'b1;
      tempN = 1'b1;
    end
    if (stb.tick) begin
      if (!hempN) begin
        txvN = 1'b1;
        txbN = thrN;
        hempN = 1'b1;
        tempN = 1'b1;
      end
      if (rxValid) begin
        if (rdrN) ovrN = 1'b1;
        rbrN = rxByte;
        rdrN = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rbr <= '0;
      thr <= '0;
      scr <= '0;
      dll <= '0;
      dlm <= '0;
      lineReg <= '0;
      rxReady <= 1'b0;
      ovr <= 1'b0;
      holdEmpty <= 1'b1;
      txEmpty <= 1'b1;
      busErr <= 1'b0;
      txValid <= 1'b0;
      txByte <= '0;
    end else begin
      rbr <= rbrN;
      thr <= thrN;
      rxReady <= rdrN;
      ovr <= ovrN;
      holdEmpty <= hempN;
      txEmpty <= tempN;
      txValid <= txvN;
      txByte <= txbN;
      if (stb.illegal) busErr <= 1'b1;
      if (stb.scrWr) scr <= busWdata;
      if (stb.dllWr) dll <= busWdata;
      if (stb.dlmWr) dlm <= busWdata;
      if (stb.lineWr) lineReg <= busWdata;
    end
  end

  always_comb begin
    case (rdSel)
      SEL_RBR: busRdata = rbr;
      SEL_DLL: busRdata = dll;
      SEL_DLM: busRdata = dlm;
      SEL_LINE: busRdata = lineReg;
      SEL_STAT: busRdata = statVal;
      SEL_SCR: busRdata = scr;
      default: busRdata = '0;
    endcase
  end

  // R10: flag consistency
  p_temt_hemp_r10: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> holdEmpty);
  p_cnt0_hemp_r10: assert property (@(posedge clk) disable iff (!rstN)
    (slotCnt == '0) |-> holdEmpty);
  // R8: error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    busErr |=> busErr);
  // R4: a transmit pulse follows a tick
  p_tx_on_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(stb.tick));
  // R5: data-ready only rises from a slot tick
  p_rx_on_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> $past(stb.tick && rxValid));
  // R6: overrun only rises from an arrival on a tick
  p_ovr_on_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovr) |-> $past(stb.tick && rxValid));
endmodule

// File: rtl/chr_uart.sv
module chr_uart
  import chr_uart_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  logic              busRd,
  input  logic              busWr,
  output logic [7:0]        busRdata,
  output logic              busErr,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  output logic              txValid,
  output logic [7:0]        txByte
);
  localparam int DIV_W = 2 * CHAR_W;

  strobe_t stb;
  rdSel_e rdSel;
  logic [DIV_W-1:0] slotCnt, divisor;
  logic dlab, rxReady, holdEmpty;

  chr_uart_ctrl #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .dlab(dlab), .rxReady(rxReady), .holdEmpty(holdEmpty),
    .divisor(divisor), .stb(stb), .rdSel(rdSel), .slotCnt(slotCnt)
  );

  chr_uart_dp #(.DIV_W(DIV_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .busWdata(busWdata),
    .rxValid(rxValid), .rxByte(rxByte), .slotCnt(slotCnt), .dlab(dlab),
    .rxReady(rxReady), .holdEmpty(holdEmpty), .divisor(divisor),
    .busRdata(busRdata), .busErr(busErr), .txValid(txValid), .txByte(txByte)
  );
endmodule

// File: tb/chr_uart_test.sv
module chr_uart_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic busRd = 1'b0, busWr = 1'b0;
  logic [7:0] busRdata;
  logic busErr;
  logic rxValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic txValid;
  logic [7:0] txByte;

  int checks = 0, fails = 0, cyc = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  chr_uart uut (.*);

  // behavioural reference
  int mDll, mDlm, mLcr, mScr, mRbr, mThr, mCnt;
  bit mRdr, mOe, mThre, mTemt, mErr, mTxV;
  int mTxB;

  function automatic int mRead();
    bit dl = mLcr[7];
    if (!busRd || busWr) return 0;
    case (busAddr)
      0: return dl ? mDll : (mRdr ? mRbr : 0);
      4: return dl ? mDlm : 0;
      12: return mLcr;
      20: return (int'(mTemt) << 6) | (int'(mThre) << 5) | (int'(mOe) << 1) | int'(mRdr);
      28: return mScr;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mDll = 0; mDlm = 0; mLcr = 0; mScr = 0; mRbr = 0; mThr = 0; mCnt = 0;
      mRdr = 0; mOe = 0; mThre = 1; mTemt = 1; mErr = 0; mTxV = 0; mTxB = 0;
    end else begin
      int b;
      bit tick, dl, bad;
      b = (mDlm * 256 + mDll == 0) ? 1 : mDlm * 256 + mDll;
      tick = (mCnt >= b - 1);
      dl = mLcr[7];
      bad = 0;
      if (busRd && busWr) bad = 1;
      else if (busRd) begin
        case (busAddr)
          0: if (!dl) begin if (mRdr) mRdr = 0; else bad = 1; end
          4: if (!dl) bad = 1;
          12, 28: ;
          20: mOe = 0;
          default: bad = 1;
        endcase
      end else if (busWr) begin
        case (busAddr)
          0: if (dl) mDll = busWdata;
             else if (mThre) begin mThr = busWdata; mThre = 0; mTemt = 0; end
             else bad = 1;
          4: if (dl) mDlm = busWdata; else bad = 1;
          8: if (busWdata == 8'h01) begin mRdr = 0; mOe = 0; mThre = 1; mTemt = 1; end
             else bad = 1;
          12: mLcr = busWdata;
          28: mScr = busWdata;
          default: bad = 1;
        endcase
      end
      if (bad) mErr = 1;
      mTxV = 0;
      if (tick) begin
        if (!mThre) begin mTxV = 1; mTxB = mThr; mThre = 1; mTemt = 1; end
        if (rxValid) begin
          if (mRdr) mOe = 1;
          mRbr = rxByte;
          mRdr = 1;
        end
      end
      mCnt = tick ? 0 : mCnt + 1;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      chk(curReq, "ref busRdata", int'(busRdata), mRead());
      chk(curReq, "ref busErr", int'(busErr), int'(mErr));
      chk(curReq, "ref txValid", int'(txValid), int'(mTxV));
      if (mTxV) chk(curReq, "ref txByte", int'(txByte), mTxB);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int a, input int d);
    busAddr = 5'(a); busWdata = 8'(d); busWr = 1'b1;
    step();
    busWr = 1'b0;
  endtask

  task automatic rdChk(input int a, input int exp, input string req);
    busAddr = 5'(a); busRd = 1'b1;
    @(negedge clk);
    chk(req, $sformatf("read @%0d", a), int'(busRdata), exp);
    @(posedge clk); #1;
    busRd = 1'b0;
  endtask

  task automatic rxPut(input int d);
    rxValid = 1'b1; rxByte = 8'(d);
    step();
    rxValid = 1'b0;
  endtask

  task automatic doReset();
    busRd = 0; busWr = 0; rxValid = 0;
    rstN = 1'b0;
    step(); step();
    rstN = 1'b1;
  endtask

  task automatic waitTx(output int at);
    int n = 0;
    while (!txValid && n < 70000) begin step(); n++; end
    at = cyc;
  endtask

  task automatic setDiv(input int d);
    wr(12, 8'h80); wr(0, d & 255); wr(4, d >> 8); wr(12, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int t0, t1;
    bit seen;
    doReset();
    // R1 reset state
    curReq = "R1";
    chk("R1", "err after reset", int'(busErr), 0);
    rdChk(20, 8'h60, "R1");
    rdChk(12, 8'h00, "R1");
    wr(12, 8'h80);
    rdChk(0, 0, "R1");
    rdChk(4, 0, "R1");
    wr(12, 8'h00);
    // R2 scratch and line control
    curReq = "R2";
    wr(28, 8'hC3); rdChk(28, 8'hC3, "R2");
    wr(12, 8'h1B); rdChk(12, 8'h1B, "R2"); wr(12, 0);
    // R4 transmit with b = 1: emitted at the write clock's tick
    curReq = "R4";
    wr(0, 8'h41);
    chk("R4", "txValid", int'(txValid), 1);
    chk("R4", "txByte", int'(txByte), 8'h41);
    step();
    chk("R4", "txValid one clock", int'(txValid), 0);
    // R5 receive
    curReq = "R5";
    rxPut(8'h5A);
    rdChk(20, 8'h61, "R5");
    rdChk(0, 8'h5A, "R5");
    rdChk(20, 8'h60, "R5");
    // R6 overrun
    curReq = "R6";
    rxPut(8'h11); rxPut(8'h22);
    rdChk(20, 8'h63, "R6");
    rdChk(20, 8'h61, "R6");
    rdChk(0, 8'h22, "R6");
    // R7 FIFO reset on receive side
    curReq = "R7";
    rxPut(8'h44); rxPut(8'h45);
    wr(8, 8'h01);
    rdChk(20, 8'h60, "R7");
    // R3 slot period with divisor 4
    curReq = "R3";
    setDiv(4);
    wr(0, 8'h70); waitTx(t0);
    for (int i = 1; i < 4; i++) begin
      wr(0, 8'h70 + i);
      waitTx(t1);
      chk("R3", "slot gap", t1 - t0, 4);
      chk("R4", "tx byte at b=4", int'(txByte), 8'h70 + i);
      t0 = t1;
    end
    rxValid = 1'b1; rxByte = 8'h33;
    repeat (4) step();
    rxValid = 1'b0;
    rdChk(20, 8'h61, "R3");
    rdChk(0, 8'h33, "R3");
    // R7 drops pending transmit byte
    curReq = "R7";
    setDiv(200);
    wr(0, 8'h01); waitTx(t0);
    wr(0, 8'h55);
    wr(8, 8'h01);
    rdChk(20, 8'h60, "R7");
    seen = 0;
    repeat (250) begin step(); if (txValid) seen = 1; end
    chk("R7", "dropped byte never sent", int'(seen), 0);

    // R8/R9 error cases, each after a reset
    curReq = "R8";
    doReset(); busAddr = 16; busRd = 1; step(); busRd = 0;
    chk("R8", "unmapped read err", int'(busErr), 1);
    wr(28, 8'h01); step(); step();
    chk("R8", "err sticky", int'(busErr), 1);

    doReset(); busAddr = 8; busRd = 1; step(); busRd = 0;
    chk("R8", "fifo read err", int'(busErr), 1);

    curReq = "R9";
    doReset(); wr(20, 8'hFF);
    chk("R8", "status write err", int'(busErr), 1);
    rdChk(20, 8'h60, "R9");

    doReset(); rxPut(8'h10); wr(8, 8'h03);
    chk("R8", "reserved fifo bits err", int'(busErr), 1);
    rdChk(20, 8'h61, "R9");

    doReset(); rdChk(0, 0, "R9");
    chk("R8", "empty rx read err", int'(busErr), 1);

    doReset(); wr(4, 8'h12);
    chk("R8", "offset 4 without dlab err", int'(busErr), 1);

    doReset(); setDiv(100); wr(0, 8'h01); waitTx(t0);
    wr(0, 8'hA1); wr(0, 8'hB2);
    chk("R8", "full holding write err", int'(busErr), 1);
    waitTx(t0);
    chk("R9", "first byte kept", int'(txByte), 8'hA1);

    curReq = "R11";
    doReset(); busAddr = 28; busWdata = 8'h5C; busRd = 1; busWr = 1; step();
    busRd = 0; busWr = 0;
    chk("R11", "rd+wr err", int'(busErr), 1);
    rdChk(28, 8'h00, "R11");

    // mixed random traffic against the reference (R2..R10)
    curReq = "R10";
    doReset();
    for (int i = 0; i < 4000; i++) begin
      int sel, a, d;
      sel = $urandom % 10;
      a = (sel < 3) ? 0 : (sel == 3) ? 4 : (sel == 4) ? 8 : (sel == 5) ? 12 :
          (sel == 6) ? 20 : (sel == 7) ? 28 : (sel == 8) ? 16 : 3;
      d = $urandom % 256;
      if (a == 8 && ($urandom % 2)) d = 1;
      if (mLcr[7] && a == 0) d = $urandom % 6;
      if (mLcr[7] && a == 4) d = 0;
      busAddr = 5'(a); busWdata = 8'(d);
      busRd = ($urandom % 3) == 0;
      busWr = !busRd && (($urandom % 3) == 0);
      if (($urandom % 40) == 0) busWr = busRd;
      rxValid = ($urandom % 2); rxByte = 8'($urandom);
      if ((i % 500) == 0) doReset();
      step();
    end
    busRd = 0; busWr = 0; rxValid = 0;
    step(); step();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule